// File: doc/BRIEF.md
# Partition Read/Write Protection Controller

This block sits between a host access port and a storage array. It guards a single partition, given as an inclusive range of block addresses. Reads of that range, writes to it, or both, can be marked protected. A protected access never reaches the array. A protected read returns all-ones data to the host, and a protected write is discarded. Each blocked access sets a sticky violation flag, which drives an interrupt source.

The partition bounds, the two protection attributes and a 64-bit unlock key are captured from configuration inputs while reset is held. After reset the partition is always guarded. A boot image that must be readable at power-up is therefore configured with the read attribute clear, and protection is applied later by a reset with new settings. The host unlocks the partition by writing the key as four 16-bit words, least significant word first, to four control selects. A wrong word, or a word sent out of turn, sends the sequence back to its start. A relock command or a hardware reset closes the partition again. The active-low lock input re-imposes protection while it is low, even after a correct key.

Top module: `part_guard`

## Requirements
- R1: While rst_n is low, the bounds, attributes and key are captured from the cfg_* inputs. After reset, key_open is 0 and viol_flag is 0.
- R2: A read (acc_valid=1, acc_write=0) is blocked when all of the following hold: the block is inside [lo, hi], the read attribute is set, and protection is in force. Protection is in force when key_open=0 or lock_n=0. A blocked read gives arr_req=0 and acc_rdata all ones.
- R3: A write (acc_write=1) is blocked under the same conditions when the write attribute is set. A blocked write gives arr_req=0, so the write is dropped.
- R4: An access that is not blocked gives arr_req=acc_valid, and acc_rdata=arr_rdata. This covers a block outside the range, or an access whose attribute is clear.
- R5: The key is written with ctl_we=1, one word per write. ctl_sel=0 carries key bits 15:0, ctl_sel=1 carries bits 31:16, ctl_sel=2 carries bits 47:32 and ctl_sel=3 carries bits 63:48, in that order. key_open becomes 1 on the clock edge that takes the fourth matching word.
- R6: A key write whose select is not the next expected one, or whose data does not match, returns the sequence to its start (expecting select 0). Key writes made while key_open=1 are ignored.
- R7: While lock_n=0, protection is in force regardless of the key. key_open keeps its value, so access returns when lock_n goes back to 1.
- R8: A blocked access sets viol_flag on the next clock edge. viol_flag then stays set.
- R9: A control write with ctl_sel=5 and ctl_wdata[0]=1 clears viol_flag. With ctl_wdata[0]=0 it has no effect. A blocked access in the same cycle as a clear leaves the flag set.
- R10: A control write with ctl_sel=4 (relock) makes key_open 0 on the next edge.
- R11: Both bounds are inclusive: block lo and block hi are inside the partition, and lo-1 and hi+1 are outside.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_lo_blk | input | BLK_W | Lowest protected block |
| cfg_hi_blk | input | BLK_W | Highest protected block |
| cfg_rd_prot | input | 1 | Read attribute |
| cfg_wr_prot | input | 1 | Write attribute |
| cfg_key | input | KEY_W | Unlock key |
| lock_n | input | 1 | Active-low forced protection |
| ctl_we | input | 1 | Control write strobe |
| ctl_sel | input | 3 | Control select: 0-3 key words, 4 relock, 5 clear flag |
| ctl_wdata | input | WORD_W | Control write data |
| acc_valid | input | 1 | Host access request |
| acc_write | input | 1 | Host access is a write |
| acc_blk | input | BLK_W | Host block address |
| acc_wdata | input | DATA_W | Host write data |
| acc_rdata | output | DATA_W | Read data returned to host |
| arr_req | output | 1 | Request forwarded to array |
| arr_write | output | 1 | Forwarded write flag |
| arr_blk | output | BLK_W | Forwarded block address |
| arr_wdata | output | DATA_W | Forwarded write data |
| arr_rdata | input | DATA_W | Array read data |
| key_open | output | 1 | Key accepted, partition unlocked |
| viol_flag | output | 1 | Sticky violation flag |

## Verification
The key sequencer state is visible at the ports only through key_open. The position of a sequence that has not finished shows up only when the next key word is written. For this reason the bench sends sequences that break at the second word and at the third select, and then checks that a complete sequence is still needed. A wrong range or attribute decision shows up in the same cycle as the access, on arr_req and acc_rdata. A violation register that is wrong shows up one edge later on viol_flag. The bench also probes the inclusive edges and the case where a clear and a violation arrive together.

// File: rtl/part_guard_pkg.sv
// Shared control selects and attribute type for the partition guard.
package part_guard_pkg;
    localparam int CTL_SEL_W = 3;
    localparam logic [CTL_SEL_W-1:0] SEL_KEY_LAST = 3'd3;
    localparam logic [CTL_SEL_W-1:0] SEL_RELOCK   = 3'd4;
    localparam logic [CTL_SEL_W-1:0] SEL_VCLR     = 3'd5;

    typedef struct packed {
        logic rd;
        logic wr;
    } prot_attr_t;
endpackage

// File: rtl/pg_key_seq.sv
// Key sequencer: takes the unlock key one word per control write, least
// significant word first. Assumes KEY_W/WORD_W words, all of which have
// selects below SEL_RELOCK. A wrong or out-of-turn word restarts the
// sequence. Relock or reset closes it.
module pg_key_seq
    import part_guard_pkg::*;
#(
    parameter int KEY_W  = 64,
    parameter int WORD_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [KEY_W-1:0]     key_ref,
    input  logic                 ctl_we,
    input  logic [CTL_SEL_W-1:0] ctl_sel,
    input  logic [WORD_W-1:0]    ctl_wdata,
    output logic                 key_open
);
    localparam int NWORDS = KEY_W / WORD_W;
    localparam int CNT_W  = $clog2(NWORDS + 1);

    logic [WORD_W-1:0] ref_word [NWORDS];
    logic [WORD_W-1:0] exp_word;
    logic [CNT_W-1:0]  cnt_q;
    logic              key_wr;
    logic              in_turn;

    // slice the reference key into words
    for (genvar g = 0; g < NWORDS; g++) begin : g_slice
        assign ref_word[g] = key_ref[g*WORD_W +: WORD_W];
    end

    // pick the word the sequence expects next
    always_comb begin
        exp_word = '0;
        for (int i = 0; i < NWORDS; i++) begin
            if (i == int'(cnt_q)) exp_word = ref_word[i];
        end
    end

    assign key_wr   = ctl_we && (int'(ctl_sel) < NWORDS);
    assign in_turn  = (int'(ctl_sel) == int'(cnt_q)) && (ctl_wdata == exp_word);
    assign key_open = (int'(cnt_q) == NWORDS);

    // advance, restart or close the sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ctl_we && ctl_sel == SEL_RELOCK) begin
            cnt_q <= '0;
        end else if (key_wr && !key_open) begin
            cnt_q <= in_turn ? cnt_q + 1'b1 : '0;
        end
    end
endmodule

// File: rtl/pg_range_chk.sv
// Inclusive range compare of a block address against the partition bounds.
// Assumes lo <= hi. If the bounds are swapped, nothing is in range.
module pg_range_chk #(
    parameter int BLK_W = 12
) (
    input  logic [BLK_W-1:0] blk,
    input  logic [BLK_W-1:0] lo,
    input  logic [BLK_W-1:0] hi,
    output logic             hit
);
    // both ends count as inside
    always_comb hit = (blk >= lo) && (blk <= hi);
endmodule

// File: rtl/pg_viol_reg.sv
// Sticky violation flag. A new event wins over a clear in the same cycle.
module pg_viol_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic flag
);
    // hold until cleared, with set taking priority
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr_evt) flag <= 1'b0;
    end
endmodule

// File: rtl/part_guard.sv
// Partition guard top. Configuration is captured while reset is held low.
// Host accesses pass through combinationally, and a blocked one is masked
// from the array. Assumes the array answers a read in the same cycle.
module part_guard
    import part_guard_pkg::*;
#(
    parameter int BLK_W  = 12,
    parameter int DATA_W = 16,
    parameter int KEY_W  = 64,
    parameter int WORD_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BLK_W-1:0]     cfg_lo_blk,
    input  logic [BLK_W-1:0]     cfg_hi_blk,
    input  logic                 cfg_rd_prot,
    input  logic                 cfg_wr_prot,
    input  logic [KEY_W-1:0]     cfg_key,
    input  logic                 lock_n,
    input  logic                 ctl_we,
    input  logic [CTL_SEL_W-1:0] ctl_sel,
    input  logic [WORD_W-1:0]    ctl_wdata,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [BLK_W-1:0]     acc_blk,
    input  logic [DATA_W-1:0]    acc_wdata,
    output logic [DATA_W-1:0]    acc_rdata,
    output logic                 arr_req,
    output logic                 arr_write,
    output logic [BLK_W-1:0]     arr_blk,
    output logic [DATA_W-1:0]    arr_wdata,
    input  logic [DATA_W-1:0]    arr_rdata,
    output logic                 key_open,
    output logic                 viol_flag
);
    logic [BLK_W-1:0] lo_q, hi_q;
    logic [KEY_W-1:0] key_q;
    prot_attr_t       attr_q;
    logic             hit, enforce, rd_block, wr_block, blocked, clr_evt;

    // capture configuration while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= cfg_lo_blk;
            hi_q   <= cfg_hi_blk;
            key_q  <= cfg_key;
            attr_q <= '{rd: cfg_rd_prot, wr: cfg_wr_prot};
        end
    end

    pg_range_chk #(.BLK_W(BLK_W)) u_range (
        .blk (acc_blk),
        .lo  (lo_q),
        .hi  (hi_q),
        .hit (hit)
    );

    pg_key_seq #(.KEY_W(KEY_W), .WORD_W(WORD_W)) u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_ref   (key_q),
        .ctl_we    (ctl_we),
        .ctl_sel   (ctl_sel),
        .ctl_wdata (ctl_wdata),
        .key_open  (key_open)
    );

    // access decision: range, attribute and force-lock
    always_comb begin
        enforce  = !key_open || !lock_n;
        rd_block = acc_valid && !acc_write && hit && attr_q.rd && enforce;
        wr_block = acc_valid &&  acc_write && hit && attr_q.wr && enforce;
        blocked  = rd_block || wr_block;
        clr_evt  = ctl_we && (ctl_sel == SEL_VCLR) && ctl_wdata[0];
    end

    // forward permitted accesses, mask blocked read data
    assign arr_req   = acc_valid && !blocked;
    assign arr_write = acc_write;
    assign arr_blk   = acc_blk;
    assign arr_wdata = acc_wdata;
    assign acc_rdata = rd_block ? '1 : arr_rdata;

    pg_viol_reg u_viol (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (blocked),
        .clr_evt (clr_evt),
        .flag    (viol_flag)
    );
endmodule

// File: rtl/pg_checker.sv
// Property checker for the partition guard, bound to the top.
module pg_checker
    import part_guard_pkg::*;
#(
    parameter int BLK_W  = 12,
    parameter int DATA_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 acc_valid,
    input logic                 acc_write,
    input logic [BLK_W-1:0]     acc_blk,
    input logic [BLK_W-1:0]     lo_q,
    input logic [BLK_W-1:0]     hi_q,
    input prot_attr_t           attr_q,
    input logic                 lock_n,
    input logic                 key_open,
    input logic                 arr_req,
    input logic [DATA_W-1:0]    acc_rdata,
    input logic                 viol_flag,
    input logic                 ctl_we,
    input logic [CTL_SEL_W-1:0] ctl_sel,
    input logic                 clr_bit
);
    a_r2_rd_block: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write && acc_blk >= lo_q && acc_blk <= hi_q && attr_q.rd
        && (!key_open || !lock_n) |-> !arr_req && acc_rdata == '1);

    a_r3_wr_block: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write && acc_blk >= lo_q && acc_blk <= hi_q && attr_q.wr
        && (!key_open || !lock_n) |-> !arr_req);

    a_r4_out_pass: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && (acc_blk < lo_q || acc_blk > hi_q) |-> arr_req);

    a_r5_open_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_open) |-> $past(ctl_we && ctl_sel == SEL_KEY_LAST));

    a_r7_key_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_n && key_open && !(ctl_we && ctl_sel == SEL_RELOCK) |=> key_open);

    a_r8_viol_set: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !arr_req |=> viol_flag);

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag && !(ctl_we && ctl_sel == SEL_VCLR && clr_bit) |=> viol_flag);

    a_r10_relock: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we && ctl_sel == SEL_RELOCK |=> !key_open);
endmodule

bind part_guard pg_checker #(.BLK_W(BLK_W), .DATA_W(DATA_W)) u_pg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_blk   (acc_blk),
    .lo_q      (lo_q),
    .hi_q      (hi_q),
    .attr_q    (attr_q),
    .lock_n    (lock_n),
    .key_open  (key_open),
    .arr_req   (arr_req),
    .acc_rdata (acc_rdata),
    .viol_flag (viol_flag),
    .ctl_we    (ctl_we),
    .ctl_sel   (ctl_sel),
    .clr_bit   (ctl_wdata[0])
);

// File: tb/tb_part_guard.sv
module tb_part_guard;
    localparam logic [63:0] KEY = 64'h0123_4567_89AB_CDEF;
    localparam logic [15:0] ARR = 16'h5A5A;
    // {write, expect_pass, 2'b0, blk[11:0]} with bounds 0x100..0x1FF, both attributes set
    localparam logic [15:0] VEC [8] = '{16'h40FF, 16'h0100, 16'h01FF, 16'h4200,
                                        16'h8150, 16'hC050, 16'h0180, 16'h81FF};

    logic clk = 0, rst_n = 0;
    logic [11:0] cfg_lo_blk = 12'h100, cfg_hi_blk = 12'h1FF;
    logic cfg_rd_prot = 1, cfg_wr_prot = 1;
    logic [63:0] cfg_key = KEY;
    logic lock_n = 1, ctl_we = 0, acc_valid = 0, acc_write = 0;
    logic [2:0] ctl_sel = 0;
    logic [15:0] ctl_wdata = 0, acc_wdata = 16'h1234;
    logic [11:0] acc_blk = 0;
    logic [15:0] acc_rdata, arr_wdata;
    logic [15:0] arr_rdata = ARR;
    logic arr_req, arr_write, key_open, viol_flag;
    logic [11:0] arr_blk;
    int tests = 0, fails = 0;

    always #5 clk = ~clk;

    part_guard dut (.*);

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic ctl(input logic [2:0] sel, input logic [15:0] d);
        ctl_we = 1; ctl_sel = sel; ctl_wdata = d;
        @(negedge clk); ctl_we = 0;
    endtask

    task automatic send_key();
        for (int i = 0; i < 4; i++) ctl(3'(i), KEY[i*16 +: 16]);
    endtask

    // drive an access for one cycle, check same-cycle forwarding
    task automatic access(input logic wr, input logic [11:0] b, input bit pass, input string req);
        acc_valid = 1; acc_write = wr; acc_blk = b;
        #1;
        check(arr_req == pass, req, arr_req, pass);
        if (!wr) check(acc_rdata == (pass ? ARR : 16'hFFFF), req, acc_rdata, pass ? ARR : 16'hFFFF);
        @(negedge clk); acc_valid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check(key_open == 0, "R1 key_open", key_open, 0);
        check(viol_flag == 0, "R1 viol_flag", viol_flag, 0);
        // R2 R3 R4 R11 table walk
        for (int i = 0; i < 8; i++)
            access(VEC[i][15], VEC[i][11:0], VEC[i][14], "R2/R3/R4/R11 vector");
        // R8 sticky flag after blocks
        check(viol_flag == 1, "R8 flag set", viol_flag, 1);
        access(0, 12'h050, 1, "R4 pass");
        check(viol_flag == 1, "R8 sticky", viol_flag, 1);
        // R9 clear
        ctl(3'd5, 16'h0000);
        check(viol_flag == 1, "R9 clear bit0=0 ignored", viol_flag, 1);
        ctl(3'd5, 16'h0001);
        check(viol_flag == 0, "R9 cleared", viol_flag, 0);
        // R9 set wins over clear
        ctl_we = 1; ctl_sel = 3'd5; ctl_wdata = 16'h0001;
        acc_valid = 1; acc_write = 0; acc_blk = 12'h120;
        @(negedge clk); ctl_we = 0; acc_valid = 0;
        check(viol_flag == 1, "R9 set beats clear", viol_flag, 1);
        ctl(3'd5, 16'h0001);
        // R5 unlock
        for (int i = 0; i < 3; i++) ctl(3'(i), KEY[i*16 +: 16]);
        check(key_open == 0, "R5 not open after three words", key_open, 0);
        ctl(3'd3, KEY[63:48]);
        check(key_open == 1, "R5 open after fourth", key_open, 1);
        access(0, 12'h150, 1, "R5 read allowed");
        access(1, 12'h100, 1, "R5 write allowed");
        check(viol_flag == 0, "R8 no violation when open", viol_flag, 0);
        // R6 key write while open ignored
        ctl(3'd0, 16'hDEAD);
        check(key_open == 1, "R6 ignored while open", key_open, 1);
        // R7 force lock
        lock_n = 0;
        access(0, 12'h150, 0, "R7 lock blocks read");
        access(1, 12'h150, 0, "R7 lock blocks write");
        lock_n = 1;
        check(key_open == 1, "R7 key kept", key_open, 1);
        access(0, 12'h150, 1, "R7 released");
        // R10 relock
        ctl(3'd4, 16'h0000);
        check(key_open == 0, "R10 relock", key_open, 0);
        access(0, 12'h150, 0, "R10 blocked again");
        // R6 wrong data then rest
        ctl(3'd0, KEY[15:0]); ctl(3'd1, 16'h0000);
        ctl(3'd2, KEY[47:32]); ctl(3'd3, KEY[63:48]);
        check(key_open == 0, "R6 mismatch restarts", key_open, 0);
        // R6 out of turn
        ctl(3'd0, KEY[15:0]); ctl(3'd2, KEY[47:32]);
        ctl(3'd1, KEY[31:16]); ctl(3'd3, KEY[63:48]);
        check(key_open == 0, "R6 out of turn restarts", key_open, 0);
        send_key();
        check(key_open == 1, "R6 full sequence recovers", key_open, 1);
        // R1 reset relocks; new attributes: write-only, bounds 0x010..0x01F
        cfg_rd_prot = 0; cfg_lo_blk = 12'h010; cfg_hi_blk = 12'h01F;
        do_reset();
        check(key_open == 0, "R1 reset relocks", key_open, 0);
        check(viol_flag == 0, "R1 flag cleared", viol_flag, 0);
        access(0, 12'h010, 1, "R4 read attr clear");
        access(1, 12'h01F, 0, "R3 write blocked hi edge");
        access(1, 12'h00F, 1, "R11 lo-1 outside");
        access(1, 12'h020, 1, "R11 hi+1 outside");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule